// File: doc/BRIEF.md
# Memory-Map Control Register with RAM Window Decode

This block holds an 8-bit system control register on a 16-bit CPU address bus and decodes which side serves each CPU access. The register sits at address 0xFFC4. Two of its bits steer the memory map. The RAM-on bit decides whether a fixed 512-byte window (0xFD80 to 0xFF7F) goes to on-chip RAM or to the external bus. The dual-port-open bit lets an external host reach the dual-port RAM, but only while the chip is in single-chip mode.

The remaining writable bits are kept in the register and driven out on pins for other blocks: a standby-select flag, a 3-bit standby timer code and an NMI edge choice. The CPU writes the register with a write strobe. The new value is stored on that clock edge, and the decode uses it from the next cycle on. Read data is combinational. All selects are combinational from the address, the strobes, the mode pin and the stored bits.

Top module: `mmap_ctl`

## Requirements
- R1: After a synchronous reset, a read of 0xFFC4 returns 0x09. This means bit 0 (RAM-on) = 1, bit 3 = 1, and every other bit = 0.
- R2: A write strobe at 0xFFC4 stores write data on that clock edge, and reads from the next cycle return it. The field positions are: bit 7 standby select, bits 6..4 standby timer, bit 2 NMI edge, bit 1 dual-port open, bit 0 RAM-on.
- R3: Bit 3 is reserved. It always reads as 1, and write data on bit 3 has no effect.
- R4: While RAM-on is 1, a read or write to any address from 0xFD80 to 0xFF7F asserts `ram_sel` and deasserts `ext_sel`.
- R5: While RAM-on is 0, a read or write in that same window asserts `ext_sel` and deasserts `ram_sel`.
- R6: A read or write outside the window, at any address other than 0xFFC4, asserts `ext_sel` and deasserts `ram_sel`. This includes 0xFD7F and 0xFF80.
- R7: A read or write at 0xFFC4 asserts neither `ram_sel` nor `ext_sel`.
- R8: With neither the read strobe nor the write strobe high, both selects are 0.
- R9: `cpu_rdata` is 0 unless the read strobe is high and the address is 0xFFC4.
- R10: `dpram_host_en` is 1 only while the dual-port-open bit is 1 and `mode_single` is 1. In expanded mode (`mode_single` = 0) it stays 0.
- R11: The sleep and software-standby inputs do not change the stored register. Only reset or a write at 0xFFC4 changes it.
- R12: `standby_sel`, `standby_timer` and `nmi_edge` follow register bits 7, 6..4 and 2.
- R13: A write at any address other than 0xFFC4 leaves the register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe |
| cpu_wr | input | 1 | Write strobe |
| cpu_rdata | output | 8 | Read data, zero when the register is not being read |
| mode_single | input | 1 | 1 = single-chip mode, 0 = expanded mode |
| in_sleep | input | 1 | Sleep mode indication |
| in_sw_standby | input | 1 | Software standby indication |
| ram_sel | output | 1 | On-chip RAM select |
| ext_sel | output | 1 | External bus select |
| dpram_host_en | output | 1 | Dual-port RAM open to the external host |
| standby_sel | output | 1 | Stored standby-select bit |
| standby_timer | output | 3 | Stored standby timer code |
| nmi_edge | output | 1 | Stored NMI edge choice |

## Verification
The selects, the read data and `dpram_host_en` are combinational, so each is due in the same cycle as the address and strobes that produce it. The effect of a register write shows up one clock later. The bench drives each vector just after a falling edge and compares it 2 ns later, well before the next rising edge. Its reference register is updated only after a write vector's expectation has been formed. That way, a vector that writes is checked against the old value, and every later vector is checked against the new one.

// File: rtl/mmap_ctl_pkg.sv
package mmap_ctl_pkg;

    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int WIN_BYTES = 512;

    localparam logic [ADDR_W-1:0] CTL_ADDR = 16'hFFC4;
    localparam logic [ADDR_W-1:0] WIN_BASE = 16'hFD80;
    localparam logic [ADDR_W-1:0] WIN_LAST = WIN_BASE + ADDR_W'(WIN_BYTES - 1);

    // Control register layout (bit positions are decoded by neighbours)
    typedef struct packed {
        logic       stby;      // bit 7
        logic [2:0] stby_tmr;  // bits 6..4
        logic       rsvd;      // bit 3, reads 1
        logic       nmi_edge;  // bit 2
        logic       dp_open;   // bit 1
        logic       ram_on;    // bit 0
    } ctl_reg_t;

    localparam ctl_reg_t CTL_RESET = '{stby: 1'b0, stby_tmr: 3'd0, rsvd: 1'b1,
                                       nmi_edge: 1'b0, dp_open: 1'b0, ram_on: 1'b1};

    // Map CPU write data onto the register, forcing the reserved bit
    function automatic ctl_reg_t pack_write(input logic [DATA_W-1:0] d);
        ctl_reg_t r;
        r      = ctl_reg_t'(d);
        r.rsvd = 1'b1;
        return r;
    endfunction

    // Decoder output bundle
    typedef struct packed {
        logic ram;
        logic ext;
        logic dp_host;
    } sel_t;

endpackage

// File: rtl/mmap_ctl_reg.sv
module mmap_ctl_reg
    import mmap_ctl_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_hit,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          in_sleep,
    input  logic          in_sw_standby,
    output ctl_reg_t      ctl,
    output logic [DW-1:0] rdata
);

    logic wr_hit;
    logic rd_hit;

    assign wr_hit = reg_hit && cpu_wr;
    assign rd_hit = reg_hit && cpu_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= CTL_RESET;
        end else if (wr_hit) begin
            ctl <= pack_write(cpu_wdata);
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_hit) begin
            rdata = DW'(ctl);
        end
    end

    // R2: a register write lands on the next edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> (ctl.ram_on == $past(cpu_wdata[0]) && ctl.stby == $past(cpu_wdata[7])));

    // R3: reserved bit reads as one
    p_rsvd_one_r3: assert property (@(posedge clk) disable iff (rst)
        rd_hit |-> rdata[3]);

    // R11: low-power indications never alter the register
    p_hold_lowpower_r11: assert property (@(posedge clk) disable iff (rst)
        ((in_sleep || in_sw_standby) && !wr_hit) |=> $stable(ctl));

    // R13: no write hit, no change
    p_hold_nowrite_r13: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(ctl));

endmodule

// File: rtl/mmap_ctl_decode.sv
module mmap_ctl_decode
    import mmap_ctl_pkg::*;
#(
    parameter int                AW        = ADDR_W,
    parameter logic [AW-1:0]     REG_ADDR  = CTL_ADDR,
    parameter logic [AW-1:0]     BASE      = WIN_BASE,
    parameter int                SPAN      = WIN_BYTES
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    input  logic          mode_single,
    input  logic          ram_on,
    input  logic          dp_open,
    output logic          reg_hit,
    output sel_t          sel
);

    localparam logic [AW-1:0] LAST = BASE + AW'(SPAN - 1);

    logic access;
    logic in_win;

    assign access  = cpu_rd || cpu_wr;
    assign reg_hit = (cpu_addr == REG_ADDR);
    assign in_win  = (cpu_addr >= BASE) && (cpu_addr <= LAST);

    always_comb begin
        sel         = '0;
        sel.dp_host = dp_open && mode_single;
        if (access && !reg_hit) begin
            if (in_win && ram_on) begin
                sel.ram = 1'b1;
            end else begin
                sel.ext = 1'b1;
            end
        end
    end

    // R4: on-chip and external selects never both fire
    p_sel_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sel.ram, sel.ext}));

    // R7: register access claims neither memory side
    p_reg_no_sel_r7: assert property (@(posedge clk) disable iff (rst)
        (reg_hit && access) |-> !(sel.ram || sel.ext));

    // R8: no strobe, no select
    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !access |-> !(sel.ram || sel.ext));

    // R10: expanded mode keeps the host out
    p_dp_expanded_r10: assert property (@(posedge clk) disable iff (rst)
        !mode_single |-> !sel.dp_host);

endmodule

// File: rtl/mmap_ctl.sv
module mmap_ctl
    import mmap_ctl_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    output logic [7:0]  cpu_rdata,
    input  logic        mode_single,
    input  logic        in_sleep,
    input  logic        in_sw_standby,
    output logic        ram_sel,
    output logic        ext_sel,
    output logic        dpram_host_en,
    output logic        standby_sel,
    output logic [2:0]  standby_timer,
    output logic        nmi_edge
);

    ctl_reg_t ctl;
    sel_t     sel;
    logic     reg_hit;

    mmap_ctl_decode #(
        .AW       (ADDR_W),
        .REG_ADDR (CTL_ADDR),
        .BASE     (WIN_BASE),
        .SPAN     (WIN_BYTES)
    ) u_decode (
        .clk         (clk),
        .rst         (rst),
        .cpu_addr    (cpu_addr),
        .cpu_rd      (cpu_rd),
        .cpu_wr      (cpu_wr),
        .mode_single (mode_single),
        .ram_on      (ctl.ram_on),
        .dp_open     (ctl.dp_open),
        .reg_hit     (reg_hit),
        .sel         (sel)
    );

    mmap_ctl_reg #(
        .DW (DATA_W)
    ) u_reg (
        .clk           (clk),
        .rst           (rst),
        .reg_hit       (reg_hit),
        .cpu_rd        (cpu_rd),
        .cpu_wr        (cpu_wr),
        .cpu_wdata     (cpu_wdata),
        .in_sleep      (in_sleep),
        .in_sw_standby (in_sw_standby),
        .ctl           (ctl),
        .rdata         (cpu_rdata)
    );

    assign ram_sel       = sel.ram;
    assign ext_sel       = sel.ext;
    assign dpram_host_en = sel.dp_host;
    assign standby_sel   = ctl.stby;
    assign standby_timer = ctl.stby_tmr;
    assign nmi_edge      = ctl.nmi_edge;

    // R12: exported fields follow the stored register
    p_fields_r12: assert property (@(posedge clk) disable iff (rst)
        (reg_hit && cpu_rd) |-> (cpu_rdata[7] == standby_sel && cpu_rdata[2] == nmi_edge));

endmodule

// File: tb/mmap_ctl_tb.sv
module mmap_ctl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic        mode_single = 1'b1;
    logic        in_sleep = 1'b0;
    logic        in_sw_standby = 1'b0;
    logic        ram_sel;
    logic        ext_sel;
    logic        dpram_host_en;
    logic        standby_sel;
    logic [2:0]  standby_timer;
    logic        nmi_edge;

    always #4 clk = ~clk;  // 125 MHz

    mmap_ctl u_dut (
        .clk           (clk),
        .rst           (rst),
        .cpu_addr      (cpu_addr),
        .cpu_wdata     (cpu_wdata),
        .cpu_rd        (cpu_rd),
        .cpu_wr        (cpu_wr),
        .cpu_rdata     (cpu_rdata),
        .mode_single   (mode_single),
        .in_sleep      (in_sleep),
        .in_sw_standby (in_sw_standby),
        .ram_sel       (ram_sel),
        .ext_sel       (ext_sel),
        .dpram_host_en (dpram_host_en),
        .standby_sel   (standby_sel),
        .standby_timer (standby_timer),
        .nmi_edge      (nmi_edge)
    );

    typedef struct {
        logic [7:0] rdata;
        logic       ram;
        logic       ext;
        logic       dp;
        logic [4:0] fields;
        string      req;
    } exp_t;

    exp_t q[$];
    int   n_vec  = 0;
    int   n_fail = 0;
    logic [7:0] m_reg = 8'h09;
    bit   done = 1'b0;

    // Driver: apply a vector and push what the requirements predict
    task automatic step(input logic [15:0] a, input logic [7:0] d, input logic rd,
                        input logic wr, input logic mode, input logic slp,
                        input logic sbs, input string req);
        exp_t e;
        logic win;
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_rd = rd; cpu_wr = wr;
        mode_single = mode; in_sleep = slp; in_sw_standby = sbs;
        win      = (a >= 16'hFD80) && (a <= 16'hFF7F);
        e.rdata  = (rd && a == 16'hFFC4) ? (m_reg | 8'h08) : 8'h00;
        e.ram    = (rd || wr) && a != 16'hFFC4 && win && m_reg[0];
        e.ext    = (rd || wr) && a != 16'hFFC4 && !(win && m_reg[0]);
        e.dp     = m_reg[1] && mode;
        e.fields = {m_reg[7:4], m_reg[2]};
        e.req    = req;
        q.push_back(e);
        if (wr && a == 16'hFFC4) m_reg = d | 8'h08;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cpu_rd = 1'b0; cpu_wr = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        m_reg = 8'h09;
    endtask

    // Monitor: compare each pushed item 2 ns after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_vec++;
                if (cpu_rdata !== e.rdata) begin
                    n_fail++;
                    $display("FAIL %s rdata actual=%h expected=%h", e.req, cpu_rdata, e.rdata);
                end
                if (ram_sel !== e.ram || ext_sel !== e.ext) begin
                    n_fail++;
                    $display("FAIL %s ram/ext actual=%b%b expected=%b%b", e.req,
                             ram_sel, ext_sel, e.ram, e.ext);
                end
                if (dpram_host_en !== e.dp) begin
                    n_fail++;
                    $display("FAIL %s dp actual=%b expected=%b", e.req, dpram_host_en, e.dp);
                end
                if ({standby_sel, standby_timer, nmi_edge} !== e.fields) begin
                    n_fail++;
                    $display("FAIL %s fields actual=%b expected=%b", e.req,
                             {standby_sel, standby_timer, nmi_edge}, e.fields);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset();
        step(16'hFFC4, 8'h00, 1, 0, 1, 0, 0, "R1 reset value");
        step(16'hFD80, 8'h00, 0, 0, 1, 0, 0, "R8 idle no select");
        step(16'hFFC4, 8'h00, 0, 0, 1, 0, 0, "R9 no strobe rdata zero");
        step(16'hFD7F, 8'h00, 1, 0, 1, 0, 0, "R6 below window");
        step(16'hFD80, 8'h00, 1, 0, 1, 0, 0, "R4 window low edge");
        step(16'hFF7F, 8'h00, 0, 1, 1, 0, 0, "R4 window high edge write");
        step(16'hFF80, 8'h00, 1, 0, 1, 0, 0, "R6 above window");
        step(16'h1234, 8'h00, 1, 0, 1, 0, 0, "R9 other address rdata zero");
        // clear everything, reserved bit written 0
        step(16'hFFC4, 8'h00, 0, 1, 1, 0, 0, "R7 register write no select");
        step(16'hFFC4, 8'h00, 1, 0, 1, 0, 0, "R3 reserved reads one");
        step(16'hFD7F, 8'h00, 1, 0, 1, 0, 0, "R5 disabled below");
        step(16'hFD80, 8'h00, 1, 0, 1, 0, 0, "R5 disabled low edge");
        step(16'hFF7F, 8'h00, 1, 0, 1, 0, 0, "R5 disabled high edge");
        step(16'hFF80, 8'h00, 1, 0, 1, 0, 0, "R5 disabled above");
        // fields and dual-port open, reserved written 0
        step(16'hFFC4, 8'hF6, 0, 1, 1, 0, 0, "R2 write fields");
        step(16'hFFC4, 8'h00, 1, 0, 1, 0, 0, "R2 R12 readback");
        step(16'h0000, 8'h00, 0, 0, 1, 0, 0, "R10 single-chip open");
        step(16'h0000, 8'h00, 0, 0, 0, 0, 0, "R10 expanded closed");
        step(16'hFFC5, 8'h01, 0, 1, 0, 0, 0, "R13 write elsewhere");
        step(16'hFFC4, 8'h00, 1, 0, 0, 0, 0, "R13 register unchanged");
        step(16'hFD80, 8'h00, 1, 0, 1, 1, 0, "R11 sleep");
        step(16'hFD80, 8'h00, 1, 0, 1, 0, 1, "R11 sw standby");
        step(16'hFFC4, 8'h00, 1, 0, 1, 1, 1, "R11 both held");
        // write during sleep still lands
        step(16'hFFC4, 8'h01, 0, 1, 1, 1, 0, "R2 write in sleep");
        step(16'hFFC4, 8'h00, 1, 0, 1, 0, 0, "R2 R10 readback closed");
        step(16'hFF7F, 8'h00, 1, 0, 1, 0, 0, "R4 re-enabled");
        step(16'hFFC4, 8'h2B, 0, 1, 0, 0, 0, "R12 write timer");
        step(16'hFFC4, 8'h00, 1, 0, 0, 0, 0, "R12 R10 expanded readback");
        step(16'hFFC4, 8'h00, 1, 0, 1, 0, 0, "R10 single-chip readback");
        do_reset();
        step(16'hFFC4, 8'h00, 1, 0, 1, 0, 0, "R1 second reset");
        step(16'hFD80, 8'h00, 1, 0, 1, 0, 0, "R4 after reset");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule